// File: doc/BRIEF.md
# Four-Lane SIMD Arithmetic Unit

This block is the execution stage of a small vector unit. It operates on 32-bit vector registers through four processing elements, each owning one 8-bit slot of the register. A selected element width of 8, 16 or 32 bits gives four, two or one active elements. Lanes beyond the active count leave the matching bits of the destination operand unchanged.

In the independent configuration, every active element gets its own result. The operations are addition, multiplication, multiply-accumulate into the destination, rectification and signed maximum. In the chained configuration, the lanes pass a running accumulator from lane 0 upward. A single pass then produces a sum, a maximum or a dot product over all active elements, starting from a scalar seed, and writes it to element 0.

Each operation takes one cycle. Operands presented with `op_valid` at one rising edge produce `res_valid` and `res_data` at the next rising edge. `res_data` holds its value while no operation is issued.

Top module: `simd4_alu`

## Requirements
- R1: Reset is synchronous and active high. It clears `res_valid` and `res_data` to zero. After reset, `res_valid` equals `op_valid` from the previous edge. `res_data` is loaded only on an edge where `op_valid` is high and otherwise keeps its value.
- R2: `sew` code 0 selects 8-bit elements, code 1 selects 16-bit elements and code 2 selects 32-bit elements. Element k occupies bits [k*W +: W], where W is the element width. Code 3 is reserved and returns `vd_old` unchanged. In every case, bits outside the active elements come from `vd_old`.
- R3: `opcode` 0 with `chain`=0 gives, per element, vs1 + vs2 modulo 2^W.
- R4: `opcode` 1 with `chain`=0 gives, per element, the low W bits of vs1 * vs2.
- R5: `opcode` 2 with `chain`=0 gives, per element, zero when the vs1 element is negative as a signed value, and the vs1 element otherwise.
- R6: `opcode` 3 with `chain`=0 gives, per element, the larger of vs1 and vs2 compared as signed values.
- R7: `opcode` 4 with `chain`=0 gives, per element, vd_old + vs1 * vs2 modulo 2^W.
- R8: `opcode` 0 with `chain`=1 writes (seed + sum of all active vs1 elements) mod 2^W to element 0. The seed is the low W bits of `seed`.
- R9: `opcode` 3 with `chain`=1 writes to element 0 the signed maximum of the seed and all active vs1 elements.
- R10: `opcode` 4 with `chain`=1 writes (seed + sum over active k of vs1[k]*vs2[k]) mod 2^W to element 0.
- R11: `opcode` values 5 to 7 in either configuration return `vd_old` unchanged. So do `opcode` 1 and 2 with `chain`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| opcode | input | 3 | Operation select |
| chain | input | 1 | 0 independent lanes, 1 chained lanes |
| sew | input | 2 | Element width code |
| vs1 | input | 32 | First source vector |
| vs2 | input | 32 | Second source vector |
| vd_old | input | 32 | Current destination value |
| seed | input | 32 | Scalar start value for chained operations |
| res_valid | output | 1 | Result issued on previous edge |
| res_data | output | 32 | Registered result |

## Verification
The bench builds the block with its default parameters: four lanes of 8-bit slots and a 32-bit register. At this size every 8-bit operand pair can be swept. All 65,536 combinations of two byte values are placed in the lanes, with the operation rotating through the independent set, so every wrap, sign boundary and rectification threshold is hit for 8-bit elements. A second sweep crosses all four width codes, both configurations and all eight opcodes. It uses pseudo-random operands plus the extreme values 0x80, 0x7F, 0xFF and zero, which reach the 16- and 32-bit paths, the chained reductions and the pass-through cases.

// File: rtl/simd4_pkg.sv
package simd4_pkg;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_MUL  = 3'd1;
  localparam logic [2:0] OP_RELU = 3'd2;
  localparam logic [2:0] OP_MAX  = 3'd3;
  localparam logic [2:0] OP_MACC = 3'd4;

  localparam logic [1:0] SEW_B   = 2'd0;
  localparam logic [1:0] SEW_H   = 2'd1;
  localparam logic [1:0] SEW_W   = 2'd2;
  localparam logic [1:0] SEW_RSV = 2'd3;

  typedef struct packed {
    logic [2:0] op;
    logic       chain;
    logic [1:0] sew;
  } simd_ctrl_t;

  function automatic logic op_legal(input simd_ctrl_t c);
    logic ok;
    if (c.sew == SEW_RSV) ok = 1'b0;
    else if (c.chain)     ok = (c.op == OP_ADD) || (c.op == OP_MAX) || (c.op == OP_MACC);
    else                  ok = (c.op <= OP_MACC);
    return ok;
  endfunction

endpackage

// File: rtl/simd4_unpack.sv
module simd4_unpack #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  localparam int VLEN = LANES * EW
) (
  input  logic [VLEN-1:0]             vec_i,
  input  logic [1:0]                  sew_i,
  output logic [LANES-1:0][VLEN-1:0]  elem_o
);
  import simd4_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam bit HALF_OK = ((k + 1) * 2 * EW) <= VLEN;
    localparam bit WORD_OK = ((k + 1) * 4 * EW) <= VLEN;

    logic signed [EW-1:0]   byte_s;
    logic signed [2*EW-1:0] half_s;
    logic signed [4*EW-1:0] word_s;

    assign byte_s = vec_i[k*EW +: EW];

    if (HALF_OK) begin : g_half
      assign half_s = vec_i[k*2*EW +: 2*EW];
    end else begin : g_nohalf
      assign half_s = '0;
    end

    if (WORD_OK) begin : g_word
      assign word_s = vec_i[k*4*EW +: 4*EW];
    end else begin : g_noword
      assign word_s = '0;
    end

    always_comb begin
      case (sew_i)
        SEW_B:   elem_o[k] = VLEN'(byte_s);
        SEW_H:   elem_o[k] = VLEN'(half_s);
        SEW_W:   elem_o[k] = VLEN'(word_s);
        default: elem_o[k] = '0;
      endcase
    end
  end

endmodule

// File: rtl/simd4_lane.sv
module simd4_lane #(
  parameter int DW = 32
) (
  input  logic [2:0]    op_i,
  input  logic          active_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] acc_o
);
  import simd4_pkg::*;

  logic [DW-1:0] prod;
  logic [DW-1:0] acc_next;

  assign prod = a_i * b_i;

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_MUL:  res_o = prod;
      OP_RELU: res_o = a_i[DW-1] ? '0 : a_i;
      OP_MAX:  res_o = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
      OP_MACC: res_o = d_i + prod;
      default: res_o = d_i;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_ADD:  acc_next = acc_i + a_i;
      OP_MAX:  acc_next = ($signed(a_i) > $signed(acc_i)) ? a_i : acc_i;
      OP_MACC: acc_next = acc_i + prod;
      default: acc_next = acc_i;
    endcase
    acc_o = active_i ? acc_next : acc_i;
  end

  always_comb begin
    if (op_i == OP_RELU) begin
      a_r5_relu_nonneg: assert (res_o[DW-1] == 1'b0);
    end
    if (op_i == OP_MAX) begin
      a_r6_max_bound: assert (($signed(res_o) >= $signed(a_i)) && ($signed(res_o) >= $signed(b_i)));
    end
  end

endmodule

// File: rtl/simd4_pack.sv
module simd4_pack #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  localparam int VLEN = LANES * EW
) (
  input  logic [1:0]                 sew_i,
  input  logic                       chain_i,
  input  logic                       legal_i,
  input  logic [VLEN-1:0]            dst_i,
  input  logic [LANES-1:0][VLEN-1:0] lane_res_i,
  input  logic [VLEN-1:0]            acc_i,
  output logic [VLEN-1:0]            vec_o
);
  import simd4_pkg::*;

  localparam int NH = LANES / 2;
  localparam int NW = LANES / 4;

  always_comb begin
    vec_o = dst_i;
    if (legal_i) begin
      if (!chain_i) begin
        case (sew_i)
          SEW_B: for (int k = 0; k < LANES; k++) vec_o[k*EW +: EW]     = lane_res_i[k][EW-1:0];
          SEW_H: for (int k = 0; k < NH; k++)    vec_o[k*2*EW +: 2*EW] = lane_res_i[k][2*EW-1:0];
          SEW_W: for (int k = 0; k < NW; k++)    vec_o[k*4*EW +: 4*EW] = lane_res_i[k][4*EW-1:0];
          default: vec_o = dst_i;
        endcase
      end else begin
        case (sew_i)
          SEW_B:   vec_o[EW-1:0]   = acc_i[EW-1:0];
          SEW_H:   vec_o[2*EW-1:0] = acc_i[2*EW-1:0];
          SEW_W:   vec_o[4*EW-1:0] = acc_i[4*EW-1:0];
          default: vec_o = dst_i;
        endcase
      end
    end
  end

endmodule

// File: rtl/simd4_alu.sv
module simd4_alu #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  localparam int VLEN = LANES * EW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      opcode,
  input  logic            chain,
  input  logic [1:0]      sew,
  input  logic [VLEN-1:0] vs1,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vd_old,
  input  logic [VLEN-1:0] seed,
  output logic            res_valid,
  output logic [VLEN-1:0] res_data
);
  import simd4_pkg::*;

  simd_ctrl_t ctrl;
  logic       legal;

  assign ctrl  = '{op: opcode, chain: chain, sew: sew};
  assign legal = op_legal(ctrl);

  logic [LANES-1:0][VLEN-1:0] ea, eb, ed, lres;
  logic [LANES:0][VLEN-1:0]   acc;
  logic [LANES-1:0]           active;
  logic [VLEN-1:0]            seed_ext;
  logic [VLEN-1:0]            next_vec;

  simd4_unpack #(.LANES(LANES), .EW(EW)) u_unpack_a (.vec_i(vs1),    .sew_i(sew), .elem_o(ea));
  simd4_unpack #(.LANES(LANES), .EW(EW)) u_unpack_b (.vec_i(vs2),    .sew_i(sew), .elem_o(eb));
  simd4_unpack #(.LANES(LANES), .EW(EW)) u_unpack_d (.vec_i(vd_old), .sew_i(sew), .elem_o(ed));

  always_comb begin
    case (sew)
      SEW_B:   seed_ext = VLEN'($signed(seed[EW-1:0]));
      SEW_H:   seed_ext = VLEN'($signed(seed[2*EW-1:0]));
      SEW_W:   seed_ext = VLEN'($signed(seed[4*EW-1:0]));
      default: seed_ext = '0;
    endcase
  end

  assign acc[0] = seed_ext;

  for (genvar k = 0; k < LANES; k++) begin : g_pe
    always_comb begin
      case (sew)
        SEW_B:   active[k] = 1'b1;
        SEW_H:   active[k] = (k < LANES / 2);
        SEW_W:   active[k] = (k < LANES / 4);
        default: active[k] = 1'b0;
      endcase
    end

    simd4_lane #(.DW(VLEN)) u_lane (
      .op_i    (opcode),
      .active_i(active[k]),
      .a_i     (ea[k]),
      .b_i     (eb[k]),
      .d_i     (ed[k]),
      .acc_i   (acc[k]),
      .res_o   (lres[k]),
      .acc_o   (acc[k+1])
    );
  end

  simd4_pack #(.LANES(LANES), .EW(EW)) u_pack (
    .sew_i     (sew),
    .chain_i   (chain),
    .legal_i   (legal),
    .dst_i     (vd_old),
    .lane_res_i(lres),
    .acc_i     (acc[LANES]),
    .vec_o     (next_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= next_vec;
    end
  end

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_data));
  a_r2_reserved_sew: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sew == SEW_RSV) |=> (res_data == $past(vd_old)));
  a_r8_chain_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && chain && sew == SEW_B) |=> (res_data[VLEN-1:EW] == $past(vd_old[VLEN-1:EW])));
  a_r11_bad_op: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode > OP_MACC) |=> (res_data == $past(vd_old)));

endmodule

// File: tb/simd4_alu_tb.sv
`timescale 1ns/1ps
module simd4_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  opcode;
  logic        chain;
  logic [1:0]  sew;
  logic [31:0] vs1, vs2, vd_old, seed;
  logic        res_valid;
  logic [31:0] res_data;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  simd4_alu dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .chain(chain),
    .sew(sew), .vs1(vs1), .vs2(vs2), .vd_old(vd_old), .seed(seed),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic longint sval(input logic [63:0] v, input int w);
    if (v[w-1]) return longint'(v) - (longint'(1) << w);
    return longint'(v);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] op, input logic ch, input logic [1:0] sw,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] d, input logic [31:0] s);
    logic [31:0] res;
    logic [63:0] mask, xa, xb, xd, r, acc;
    int w, n;
    res = d;
    if (sw == 2'd3) return d;
    w = 8 << sw;
    n = 32 / w;
    mask = (64'd1 << w) - 64'd1;
    if (!ch) begin
      if (op > 3'd4) return d;
      for (int i = 0; i < n; i++) begin
        xa = (64'(a) >> (i*w)) & mask;
        xb = (64'(b) >> (i*w)) & mask;
        xd = (64'(d) >> (i*w)) & mask;
        case (op)
          3'd0: r = xa + xb;
          3'd1: r = xa * xb;
          3'd2: r = xa[w-1] ? 64'd0 : xa;
          3'd3: r = (sval(xa, w) > sval(xb, w)) ? xa : xb;
          default: r = xd + xa * xb;
        endcase
        res = (res & ~(32'(mask) << (i*w))) | (32'(r & mask) << (i*w));
      end
    end else begin
      if (!(op == 3'd0 || op == 3'd3 || op == 3'd4)) return d;
      acc = 64'(s) & mask;
      for (int i = 0; i < n; i++) begin
        xa = (64'(a) >> (i*w)) & mask;
        xb = (64'(b) >> (i*w)) & mask;
        if (op == 3'd0)      acc = acc + xa;
        else if (op == 3'd4) acc = acc + xa * xb;
        else if (sval(xa, w) > sval(acc & mask, w)) acc = xa;
        acc = acc & mask;
      end
      res = (res & ~32'(mask)) | 32'(acc);
    end
    return res;
  endfunction

  function automatic string tag(input logic [2:0] op, input logic ch, input logic [1:0] sw);
    if (sw == 2'd3) return "R2";
    if (ch) begin
      case (op)
        3'd0: return "R8";
        3'd3: return "R9";
        3'd4: return "R10";
        default: return "R11";
      endcase
    end
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic apply(input logic [2:0] op, input logic ch, input logic [1:0] sw,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic [31:0] s);
    logic [31:0] exp;
    exp = model(op, ch, sw, a, b, d, s);
    op_valid = 1'b1; opcode = op; chain = ch; sew = sw;
    vs1 = a; vs2 = b; vd_old = d; seed = s;
    @(posedge clk); #1;
    check("R1 valid", {31'd0, res_valid}, 32'd1);
    check(tag(op, ch, sw), res_data, exp);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; opcode = '0; chain = 1'b0; sew = '0;
    vs1 = '0; vs2 = '0; vd_old = '0; seed = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", {31'd0, res_valid}, 32'd0);
    check("R1 reset data", res_data, 32'd0);
    rst = 1'b0;

    // Directed corners
    apply(3'd0, 1'b0, 2'd0, 32'h7F80FF01, 32'h01800101, 32'h0, 32'h0);
    apply(3'd2, 1'b0, 2'd1, 32'h80007FFF, 32'h0, 32'h12345678, 32'h0);
    apply(3'd0, 1'b1, 2'd0, 32'h01020304, 32'h0, 32'hAABBCCDD, 32'h000000F0);
    apply(3'd3, 1'b1, 2'd0, 32'h80FF8081, 32'h0, 32'h11223344, 32'h00000090);
    apply(3'd4, 1'b1, 2'd1, 32'h00030002, 32'h00050004, 32'hDEAD0000, 32'h00000001);
    apply(3'd1, 1'b0, 2'd2, 32'h00010001, 32'h00010001, 32'h0, 32'h0);
    apply(3'd4, 1'b0, 2'd0, 32'h02020202, 32'h03030303, 32'h01010101, 32'h0);
    apply(3'd5, 1'b0, 2'd0, 32'hFFFFFFFF, 32'h1, 32'hCAFEF00D, 32'h0);
    apply(3'd0, 1'b0, 2'd3, 32'h11111111, 32'h1, 32'h0BADBEEF, 32'h0);

    // Idle cycle: result must hold (R1)
    begin
      logic [31:0] held;
      held = res_data;
      op_valid = 1'b0; vs1 = 32'h5A5A5A5A; vd_old = 32'h0;
      @(posedge clk); #1;
      check("R1 idle valid", {31'd0, res_valid}, 32'd0);
      check("R1 hold", res_data, held);
      @(negedge clk);
    end

    // Exhaustive byte-pair sweep, independent lanes, 8-bit elements
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        logic [7:0] bx, by;
        bx = 8'(x); by = 8'(y);
        apply(3'((x + y) % 5), 1'b0, 2'd0,
              {bx, by, bx ^ by, ~bx}, {by, bx, bx + by, ~by},
              {by, bx, by, bx}, 32'(x));
      end
    end

    // Cross sweep over width, configuration and opcode
    for (int sw = 0; sw < 4; sw++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int op = 0; op < 8; op++) begin
          for (int rep = 0; rep < 24; rep++) begin
            logic [31:0] a, b, d, s;
            a = $urandom; b = $urandom; d = $urandom; s = $urandom;
            if (rep == 0) begin a = 32'h80808080; b = 32'h7F7F7F7F; s = 32'h80808080; end
            if (rep == 1) begin a = 32'hFFFFFFFF; b = 32'hFFFFFFFF; s = 32'hFFFFFFFF; end
            if (rep == 2) begin a = 32'h7FFF8000; b = 32'h80007FFF; s = 32'h0; end
            if (rep == 3) begin a = 32'h0; b = 32'h0; s = 32'h7FFFFFFF; end
            apply(3'(op), 1'(ch), 2'(sw), a, b, d, s);
          end
        end
      end
    end

    op_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule